// File: doc/BRIEF.md
# Sequential Shift-Add Unsigned Multiplier

This block multiplies two unsigned WIDTH-bit operands and returns the full 2*WIDTH-bit product. It does one iteration per clock, so a product takes WIDTH cycles. The datapath is small: one WIDTH-bit multiplicand register, one 2*WIDTH-bit product register and one WIDTH-bit ripple adder.

A start pulse in an idle cycle does three things: it captures the multiplicand, places the multiplier operand in the lower half of the product register, and clears the upper half. In each busy cycle the lowest bit of the product register decides the step:
- When that bit is one, the multiplicand is added into the upper half.
- When that bit is zero, the add is skipped.

The whole register then shifts right by one. The adder's carry-out enters at the top bit, so no product bit is lost. The multiplier bits are used up from the low end as the partial product moves in from above.

A caller waits for `doneOut`. This one-cycle pulse marks the first cycle in which `productOut` holds the final value. The value then stays in place until the next accepted start.

Top module: `shift_add_mult`

## Requirements
- R1: While `rstN` is low and in the first cycle after reset, `busyOut` and `doneOut` are 0 and `productOut` is all zeros.
- R2: When the multiply finishes, `productOut` equals the unsigned product of the multiplicand and multiplier captured at the accepted start, zero-extended to 2*WIDTH bits.
- R3: A start sampled high at a rising edge while idle makes `busyOut` high with `doneOut` low for exactly WIDTH cycles. In the following cycle `doneOut` is high and `busyOut` is low.
- R4: `doneOut` is high for one cycle only. Without a new start, `productOut` keeps the final product in the cycles after `doneOut`.
- R5: A start raised while `busyOut` is high is ignored. Neither the operands it carries nor its timing affect the running multiply's result or the length of its busy period.
- R6: The carry-out of each add is kept in the product. All-ones times all-ones gives 2^(2*WIDTH) - 2^(WIDTH+1) + 1, which is 16'hFE01 for WIDTH=8.
- R7: A zero multiplicand or a zero multiplier gives a zero product and still takes the full WIDTH busy cycles.
- R8: Multiplicand 0101 times multiplier 0011 (zero-extended to WIDTH) gives 00001111, zero-extended.
- R9: A start sampled in the `doneOut` cycle is accepted. A new multiply then begins with the R3 timing.
- R10: On every iteration the product register shifts right by exactly one place: the new lower bits below the upper half are the old bits one position higher.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge active |
| rstN | input | 1 | Active-low synchronous reset |
| startIn | input | 1 | Start strobe; accepted only when not busy |
| multiplicandIn | input | WIDTH | Multiplicand operand, captured on an accepted start |
| multiplierIn | input | WIDTH | Multiplier operand, captured on an accepted start |
| busyOut | output | 1 | High while iterations are running |
| doneOut | output | 1 | One-cycle pulse: product is final |
| productOut | output | 2*WIDTH | Product register contents |

## Verification
The assertions assume that `startIn` and both operands are synchronous to `clk`, and that reset is held low at the first edge. They also assume the operands matter only in the cycle where a start is accepted, so operand values at other times are never checked. The bench drives every input at falling edges and holds each start for exactly one cycle. It changes operands only together with a start, or deliberately during busy cycles to exercise R5. As a result, each accepted start has one known pair of operands whose product is queued for comparison.

// File: rtl/mult_pkg.sv
package mult_pkg;
  typedef struct packed {
    logic load;
    logic step;
  } multStrobes_t;
endpackage

// File: rtl/mult_adder.sv
module mult_adder #(
  parameter int WIDTH = 8
) (
  input  logic [WIDTH-1:0] addA,
  input  logic [WIDTH-1:0] addB,
  output logic [WIDTH-1:0] sumOut,
  output logic             carryOut
);
  logic [WIDTH:0] carryChain;
  assign carryChain[0] = 1'b0;

  for (genvar bitIdx = 0; bitIdx < WIDTH; bitIdx++) begin : g_fa
    assign sumOut[bitIdx] = addA[bitIdx] ^ addB[bitIdx] ^ carryChain[bitIdx];
    assign carryChain[bitIdx+1] = (addA[bitIdx] & addB[bitIdx])
                                | (addA[bitIdx] & carryChain[bitIdx])
                                | (addB[bitIdx] & carryChain[bitIdx]);
  end

  assign carryOut = carryChain[WIDTH];
endmodule

// File: rtl/mult_ctrl.sv
module mult_ctrl
  import mult_pkg::*;
#(
  parameter int WIDTH = 8
) (
  input  logic         clk,
  input  logic         rstN,
  input  logic         startIn,
  output multStrobes_t strobes,
  output logic         busyOut,
  output logic         doneOut
);
  localparam int CW = $clog2(WIDTH + 1);
  localparam logic [CW-1:0] LAST = CW'(WIDTH - 1);

  typedef enum logic [1:0] {ST_IDLE, ST_RUN, ST_DONE} ctrlState_t;

  ctrlState_t state, stateNext;
  logic [CW-1:0] stepCount;
  logic accept;

  assign accept = startIn && (state != ST_RUN);

  always_comb begin
    stateNext = state;
    unique case (state)
      ST_IDLE: if (accept) stateNext = ST_RUN;
      ST_RUN:  if (stepCount == LAST) stateNext = ST_DONE;
      ST_DONE: stateNext = accept ? ST_RUN : ST_IDLE;
      default: stateNext = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      state     <= ST_IDLE;
      stepCount <= '0;
    end else begin
      state <= stateNext;
      if (accept)                stepCount <= '0;
      else if (state == ST_RUN)  stepCount <= stepCount + 1'b1;
    end
  end

  always_comb begin
    strobes.load = accept;
    strobes.step = (state == ST_RUN);
  end

  assign busyOut = (state == ST_RUN);
  assign doneOut = (state == ST_DONE);

  // R3: busy and done are never high together
  p_busy_done_excl_r3: assert property (@(posedge clk) disable iff (!rstN)
    !(busyOut && doneOut));

  // R4: done lasts a single cycle
  p_done_pulse_r4: assert property (@(posedge clk) disable iff (!rstN)
    doneOut |=> !doneOut);

  // R3: the step count advances by one each busy cycle before the last
  p_count_step_r3: assert property (@(posedge clk) disable iff (!rstN)
    (busyOut && stepCount != LAST) |=> (busyOut && stepCount == $past(stepCount) + 1'b1));

  // R5: a start while busy neither ends nor restarts the run
  p_ignore_start_r5: assert property (@(posedge clk) disable iff (!rstN)
    (busyOut && startIn && stepCount != LAST) |=> (busyOut && stepCount != '0));

  // R3: the last busy cycle is followed by done
  p_last_to_done_r3: assert property (@(posedge clk) disable iff (!rstN)
    (busyOut && stepCount == LAST) |=> doneOut);
endmodule

// File: rtl/mult_datapath.sv
module mult_datapath
  import mult_pkg::*;
#(
  parameter int WIDTH = 8
) (
  input  logic               clk,
  input  logic               rstN,
  input  multStrobes_t       strobes,
  input  logic [WIDTH-1:0]   mcandIn,
  input  logic [WIDTH-1:0]   mplierIn,
  output logic [2*WIDTH-1:0] productOut
);
  localparam int PW = 2 * WIDTH;

  logic [WIDTH-1:0] mcandReg;
  logic [PW-1:0]    prodReg;
  logic [WIDTH-1:0] addend;
  logic [WIDTH-1:0] upperSum;
  logic             upperCarry;

  assign addend = prodReg[0] ? mcandReg : '0;

  mult_adder #(.WIDTH(WIDTH)) u_adder (
    .addA     (prodReg[PW-1:WIDTH]),
    .addB     (addend),
    .sumOut   (upperSum),
    .carryOut (upperCarry)
  );

  always_ff @(posedge clk) begin
    if (!rstN) begin
      mcandReg <= '0;
      prodReg  <= '0;
    end else if (strobes.load) begin
      mcandReg <= mcandIn;
      prodReg  <= {{WIDTH{1'b0}}, mplierIn};
    end else if (strobes.step) begin
      prodReg  <= {upperCarry, upperSum, prodReg[WIDTH-1:1]};
    end
  end

  assign productOut = prodReg;

  // R10: each step moves the lower bits down by exactly one place
  p_shift_one_r10: assert property (@(posedge clk) disable iff (!rstN)
    (strobes.step && !strobes.load) |=> prodReg[WIDTH-2:0] == $past(prodReg[WIDTH-1:1]));

  // R2: the multiplicand is held for the whole run
  p_mcand_hold_r2: assert property (@(posedge clk) disable iff (!rstN)
    !strobes.load |=> $stable(mcandReg));

  // R4: with no strobe the product is held
  p_prod_hold_r4: assert property (@(posedge clk) disable iff (!rstN)
    (!strobes.load && !strobes.step) |=> $stable(prodReg));

  // R2: a load clears the upper half
  p_load_clear_r2: assert property (@(posedge clk) disable iff (!rstN)
    strobes.load |=> prodReg[PW-1:WIDTH] == '0);
endmodule

// File: rtl/shift_add_mult.sv
module shift_add_mult
  import mult_pkg::*;
#(
  parameter int WIDTH = 8
) (
  input  logic               clk,
  input  logic               rstN,
  input  logic               startIn,
  input  logic [WIDTH-1:0]   multiplicandIn,
  input  logic [WIDTH-1:0]   multiplierIn,
  output logic               busyOut,
  output logic               doneOut,
  output logic [2*WIDTH-1:0] productOut
);
  multStrobes_t strobes;

  mult_ctrl #(.WIDTH(WIDTH)) u_ctrl (
    .clk     (clk),
    .rstN    (rstN),
    .startIn (startIn),
    .strobes (strobes),
    .busyOut (busyOut),
    .doneOut (doneOut)
  );

  mult_datapath #(.WIDTH(WIDTH)) u_dp (
    .clk        (clk),
    .rstN       (rstN),
    .strobes    (strobes),
    .mcandIn    (multiplicandIn),
    .mplierIn   (multiplierIn),
    .productOut (productOut)
  );

  // R4: done result stays put when no new start arrives
  p_done_hold_r4: assert property (@(posedge clk) disable iff (!rstN)
    (doneOut && !startIn) |=> $stable(productOut));
endmodule

// File: tb/sim_shift_add_mult.sv
module sim_shift_add_mult;
  localparam int W  = 8;
  localparam int PW = 2 * W;

  logic          clk = 1'b0;
  logic          rstN = 1'b0;
  logic          startIn = 1'b0;
  logic [W-1:0]  mcand = '0;
  logic [W-1:0]  mplier = '0;
  logic          busyOut;
  logic          doneOut;
  logic [PW-1:0] productOut;

  int checks = 0;
  int failures = 0;
  logic [PW-1:0] expQ[$];
  logic [PW-1:0] lastExp;

  always #10 clk = ~clk;

  shift_add_mult #(.WIDTH(W)) u0 (
    .clk(clk), .rstN(rstN), .startIn(startIn),
    .multiplicandIn(mcand), .multiplierIn(mplier),
    .busyOut(busyOut), .doneOut(doneOut), .productOut(productOut)
  );

  task automatic check(input string req, input logic [PW-1:0] act, input logic [PW-1:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  // monitor: compares each done cycle against the scoreboard
  always @(negedge clk) begin
    if (rstN && doneOut) begin
      if (expQ.size() == 0) check("R2 unexpected done", 1, 0);
      else begin
        lastExp = expQ.pop_front();
        check("R2 product", productOut, lastExp);
      end
    end
  end

  // driver: issue a start at the current falling edge, push expected product
  task automatic issue(input logic [W-1:0] a, input logic [W-1:0] b);
    startIn = 1'b1; mcand = a; mplier = b;
    expQ.push_back(PW'(a) * PW'(b));
    @(negedge clk);
    startIn = 1'b0;
  endtask

  // timing check for R3; ignoreAt >= 0 pulses a junk start (R5)
  task automatic runTiming(input string req, input int ignoreAt);
    for (int i = 0; i < W; i++) begin
      check(req, {busyOut, doneOut}, 2'b10);
      if (i == ignoreAt) begin
        startIn = 1'b1; mcand = 8'hA7; mplier = 8'h3C;
      end else begin
        startIn = 1'b0;
      end
      @(negedge clk);
    end
    startIn = 1'b0;
    check(req, {busyOut, doneOut}, 2'b01);
  endtask

  task automatic mulOne(input logic [W-1:0] a, input logic [W-1:0] b, input string req);
    issue(a, b);
    runTiming(req, -1);
    @(negedge clk);
  endtask

  initial begin
    @(negedge clk);
    check("R1 reset flags", {busyOut, doneOut}, 2'b00);
    check("R1 reset product", productOut, '0);
    @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    check("R1 after reset", {busyOut, doneOut, productOut}, '0);

    mulOne(8'd5, 8'd3, "R8 timing");
    check("R8 value 0101x0011", productOut, 16'h000F);
    mulOne(8'hFF, 8'hFF, "R6 timing");
    check("R6 carry kept", productOut, 16'hFE01);
    mulOne(8'h00, 8'hC3, "R7 zero mcand timing");
    mulOne(8'h9D, 8'h00, "R7 zero mplier timing");
    mulOne(8'h80, 8'h02, "R2 timing");
    mulOne(8'h01, 8'hFF, "R2 timing");

    // R4: product held after done while idle
    mulOne(8'h37, 8'h59, "R4 timing");
    repeat (3) @(negedge clk);
    check("R4 hold", productOut, 16'h37 * 16'h59);
    check("R4 done low", {busyOut, doneOut}, 2'b00);

    // R5: start while busy is ignored
    issue(8'h12, 8'h34);
    runTiming("R5 ignored start timing", 3);
    @(negedge clk);
    check("R5 ignored start result", productOut, 16'h12 * 16'h34);

    // R9: start in the done cycle is accepted
    issue(8'hC8, 8'h0B);
    runTiming("R9 first timing", -1);
    issue(8'h6E, 8'hF1);
    runTiming("R9 chained timing", -1);
    @(negedge clk);
    check("R9 chained result", productOut, 16'h6E * 16'hF1);

    for (int k = 0; k < 20; k++) begin
      logic [W-1:0] ra, rb;
      ra = W'($urandom);
      rb = W'($urandom);
      mulOne(ra, rb, "R3 random timing");
    end

    check("R2 queue drained", PW'(expQ.size()), '0);
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    failures++;
    checks++;
    $display("FAIL watchdog actual=hang expected=finish");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule